// File: doc/BRIEF.md
# Page Write Buffer with Programming Timer

This block sits behind the serial protocol engine of a byte-addressed non-volatile memory. During a write transaction the engine hands over each received data byte with a load strobe. The block gathers these bytes in a one-page holding latch and keeps a valid bit for every byte position. It also keeps its own in-page write pointer. The page number is taken from the first byte of the transaction and stays fixed until the transaction ends. Each further byte goes one position higher, and the pointer wraps around inside the page.

When the engine reports a STOP, the block decides whether to program the page or throw the latched bytes away. Programming starts only under three conditions: the STOP falls in the bus clock directly after an acknowledge, the write-protect input is low, and at least one byte was loaded. The block then raises `busy_o` for a fixed number of system clocks. During that time the engine locks out the bus and refuses to acknowledge its select byte. Within that window the block scans the page from offset 0 upward. It issues one array write for every loaded position and leaves every other byte of the page untouched. The valid bits clear when the window ends.

Top module: `page_prog_buffer`

## Requirements
- R1: After reset `busy_o` and `arr_we_o` are low.
- R2: The first byte loaded after a STOP (or after reset) clears all valid bits. It takes its page from `load_addr_i[ADDR_W-1:6]` and its offset from `load_addr_i[5:0]`.
- R3: Each later byte of the same transaction is stored at the previous offset plus one, modulo 64. The page stays the same.
- R4: A STOP with `ack_win_i` high, `wp_i` low and at least one loaded byte raises `busy_o` on the next clock. `busy_o` then stays high for exactly PROG_CYCLES clocks.
- R5: While busy, offset k is presented on busy clock k (k = 0..63). `arr_we_o` is high only for loaded offsets, with `arr_addr_o` = page*64 + k and `arr_wdata_o` the latched byte. Unloaded offsets are never written.
- R6: A STOP with `ack_win_i` low starts no cycle and discards the latched bytes. A later in-window STOP with no new bytes then starts nothing.
- R7: A STOP with `wp_i` high starts no cycle, leaves the block ready at once and discards the latched bytes.
- R8: An in-window STOP with no byte loaded since the last STOP starts no cycle.
- R9: While `busy_o` is high, load, acknowledge-window and STOP inputs have no effect.
- R10: All valid bits are clear when the cycle ends, so an in-window STOP right after it starts nothing.
- R11: When more than 64 bytes arrive in one transaction, a position loaded twice holds the last byte written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | One-clock strobe: a data byte was received |
| load_addr_i | input | ADDR_W | Memory address carried with the byte (used on the first byte) |
| load_data_i | input | DATA_W | Received data byte |
| ack_win_i | input | 1 | High during the bus clock right after an acknowledge |
| stop_i | input | 1 | One-clock strobe: STOP condition seen |
| wp_i | input | 1 | Write protect, high blocks programming |
| busy_o | output | 1 | Programming cycle in progress, bus locked out |
| arr_we_o | output | 1 | Array byte write enable |
| arr_addr_o | output | ADDR_W | Array byte address |
| arr_wdata_o | output | DATA_W | Array byte write data |

## Verification
A pointer or page register that has gone wrong shows up at the array write port during the next programming cycle, because the byte lands at the wrong address. A valid bit that is lost or stuck changes the set of writes within the first 64 busy clocks after a committing STOP. It can also make an empty in-window STOP raise `busy_o` one clock later. A wrong commit decision or a wrong timer count is visible on `busy_o` either one clock after the STOP or at the exact clock where the cycle should end. A reference model therefore compares `busy_o` and the write port on every clock.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

    typedef enum logic [1:0] {
        STOP_IGNORE  = 2'd0,
        STOP_DISCARD = 2'd1,
        STOP_COMMIT  = 2'd2
    } stop_act_e;

    // Programming needs STOP in the window after an acknowledge,
    // no write protection and at least one latched byte.
    function automatic stop_act_e stop_decision(
        input logic stop,
        input logic in_window,
        input logic protect,
        input logic have_data
    );
        if (!stop)
            return STOP_IGNORE;
        if (in_window && !protect && have_data)
            return STOP_COMMIT;
        return STOP_DISCARD;
    endfunction

endpackage

// File: rtl/ppb_page_latch.sv
module ppb_page_latch #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [OFF_W-1:0]  wr_off_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              any_valid_o
);

    typedef struct packed {
        logic [PAGE_BYTES-1:0]             vld;
        logic [PAGE_BYTES-1:0][DATA_W-1:0] mem;
    } latch_t;

    latch_t lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (clr_i)
            lat_d.vld = '0;
        if (wr_i) begin
            lat_d.vld[wr_off_i] = 1'b1;
            lat_d.mem[wr_off_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lat_q <= '0;
        else
            lat_q <= lat_d;
    end

    assign rd_data_o   = lat_q.mem[rd_off_i];
    assign rd_valid_o  = lat_q.vld[rd_off_i];
    assign any_valid_o = |lat_q.vld;

    // A loaded position is marked valid on the following clock (R2)
    assert_load_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> lat_q.vld[$past(wr_off_i)]);

endmodule

// File: rtl/ppb_prog_timer.sv
module ppb_prog_timer #(
    parameter int PAGE_BYTES  = 64,
    parameter int PROG_CYCLES = 2_500_000,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             scan_act_o,
    output logic [OFF_W-1:0] scan_off_o
);

    localparam logic [CNT_W-1:0] LAST   = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] SCAN_N = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.busy = 1'b0;
                tmr_d.cnt  = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end else if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tmr_q <= '0;
        else
            tmr_q <= tmr_d;
    end

    assign busy_o     = tmr_q.busy;
    assign done_o     = tmr_q.busy && (tmr_q.cnt == LAST);
    assign scan_act_o = tmr_q.busy && (tmr_q.cnt < SCAN_N);
    assign scan_off_o = tmr_q.cnt[OFF_W-1:0];

    // Busy holds until the last count (R4)
    assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.busy && tmr_q.cnt != LAST) |=> tmr_q.busy);

    // Busy only ends from the last count (R4)
    assert_busy_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmr_q.busy) |-> ($past(tmr_q.cnt) == LAST));

endmodule

// File: rtl/page_prog_buffer.sv
module page_prog_buffer #(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 64,
    parameter int PROG_CYCLES = 2_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              ack_win_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              busy_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_addr_o,
    output logic [DATA_W-1:0] arr_wdata_o
);
    import ppb_pkg::*;

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
        logic              fresh;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              lat_clr, lat_wr, lat_rd_vld, lat_any;
    logic [OFF_W-1:0]  lat_off;
    logic [DATA_W-1:0] lat_rd_data;
    logic              tmr_start, tmr_busy, tmr_done, scan_act;
    logic [OFF_W-1:0]  scan_off;
    stop_act_e         stop_act;

    ppb_page_latch #(
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (lat_clr),
        .wr_i        (lat_wr),
        .wr_off_i    (lat_off),
        .wr_data_i   (load_data_i),
        .rd_off_i    (scan_off),
        .rd_data_o   (lat_rd_data),
        .rd_valid_o  (lat_rd_vld),
        .any_valid_o (lat_any)
    );

    ppb_prog_timer #(
        .PAGE_BYTES  (PAGE_BYTES),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (tmr_start),
        .busy_o     (tmr_busy),
        .done_o     (tmr_done),
        .scan_act_o (scan_act),
        .scan_off_o (scan_off)
    );

    assign stop_act = stop_decision(stop_i, ack_win_i, wp_i, lat_any);

    always_comb begin
        ctl_d     = ctl_q;
        lat_clr   = 1'b0;
        lat_wr    = 1'b0;
        lat_off   = ctl_q.off;
        tmr_start = 1'b0;
        if (tmr_busy) begin
            // bus locked out; only the end of the cycle matters
            if (tmr_done)
                lat_clr = 1'b1;
        end else if (stop_act != STOP_IGNORE) begin
            ctl_d.fresh = 1'b1;
            if (stop_act == STOP_COMMIT)
                tmr_start = 1'b1;
            else
                lat_clr = 1'b1;
        end else if (load_i) begin
            lat_wr = 1'b1;
            if (ctl_q.fresh) begin
                ctl_d.page  = load_addr_i[ADDR_W-1:OFF_W];
                lat_off     = load_addr_i[OFF_W-1:0];
                lat_clr     = 1'b1;
                ctl_d.fresh = 1'b0;
            end
            ctl_d.off = lat_off + OFF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.fresh <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o      = tmr_busy;
    assign arr_we_o    = scan_act && lat_rd_vld;
    assign arr_addr_o  = {ctl_q.page, scan_off};
    assign arr_wdata_o = lat_rd_data;

    // A cycle only starts from a qualifying STOP (R4)
    assert_start_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i && ack_win_i && !wp_i && lat_any));

    // Write protection keeps the block ready (R7)
    assert_wp_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && wp_i) |=> !busy_o);

    // Empty transaction never programs (R8)
    assert_empty_no_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && ack_win_i && !lat_any) |=> !busy_o);

    // Page does not move while the bus is locked out (R9)
    assert_page_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(ctl_q.page));

    // No byte stays marked after the cycle (R10)
    assert_valid_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !lat_any);

endmodule

// File: tb/page_prog_buffer_bench.sv
module page_prog_buffer_bench;

    localparam int ADDR_W = 9;
    localparam int DATA_W = 8;
    localparam int PB     = 64;
    localparam int PC     = 80;
    localparam int MEMN   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_i = 1'b0;
    logic [ADDR_W-1:0] load_addr_i = '0;
    logic [DATA_W-1:0] load_data_i = '0;
    logic              ack_win_i = 1'b0;
    logic              stop_i = 1'b0;
    logic              wp_i = 1'b0;
    logic              busy_o, arr_we_o;
    logic [ADDR_W-1:0] arr_addr_o;
    logic [DATA_W-1:0] arr_wdata_o;

    always #2 clk = ~clk;

    page_prog_buffer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PB), .PROG_CYCLES(PC)
    ) u_page_prog_buffer (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_addr_i(load_addr_i),
        .load_data_i(load_data_i), .ack_win_i(ack_win_i), .stop_i(stop_i),
        .wp_i(wp_i), .busy_o(busy_o), .arr_we_o(arr_we_o),
        .arr_addr_o(arr_addr_o), .arr_wdata_o(arr_wdata_o)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [7:0] dut_mem [MEMN];

    // behavioural reference state
    bit        m_busy, m_fresh;
    int        m_cnt, m_page, m_off;
    bit [63:0] m_vld;
    int        m_dat [64];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_fresh = 1; m_cnt = 0; m_page = 0; m_off = 0; m_vld = '0;
        end else if (m_busy) begin
            if (m_cnt == PC - 1) begin
                m_busy = 0; m_cnt = 0; m_vld = '0;
            end else begin
                m_cnt++;
            end
        end else if (stop_i) begin
            m_fresh = 1;
            if (ack_win_i && !wp_i && (m_vld != 0)) begin
                m_busy = 1; m_cnt = 0;
            end else begin
                m_vld = '0;
            end
        end else if (load_i) begin
            if (m_fresh) begin
                m_page = int'(load_addr_i) / PB;
                m_off  = int'(load_addr_i) % PB;
                m_vld  = '0;
                m_fresh = 0;
            end
            m_vld[m_off] = 1'b1;
            m_dat[m_off] = int'(load_data_i);
            m_off = (m_off + 1) % PB;
        end
    end

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_we;
            exp_we = m_busy && (m_cnt < PB) && m_vld[m_cnt];
            chk("R4 busy", int'(busy_o), int'(m_busy));
            chk("R5 write enable", int'(arr_we_o), int'(exp_we));
            if (exp_we) begin
                chk("R5 write address", int'(arr_addr_o), m_page * PB + m_cnt);
                chk("R5 write data", int'(arr_wdata_o), m_dat[m_cnt]);
            end
            if (arr_we_o)
                dut_mem[arr_addr_o] = arr_wdata_o;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic send_byte(input int addr, input int data);
        load_i = 1'b1;
        load_addr_i = ADDR_W'(addr);
        load_data_i = DATA_W'(data);
        @(negedge clk);
        load_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_stop(input bit win, input bit prot);
        ack_win_i = win;
        wp_i = prot;
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        ack_win_i = 1'b0;
        wp_i = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy_o && n < 10 * PC) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        for (int i = 0; i < MEMN; i++) dut_mem[i] = 8'hEE;
        repeat (3) @(negedge clk);
        chk("R1 busy at reset", int'(busy_o), 0);
        chk("R1 write enable at reset", int'(arr_we_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R5: page 2, offsets 10..12
        send_byte(138, 8'h11);
        send_byte(0,   8'h22);
        send_byte(0,   8'h33);
        send_stop(1, 0);
        chk("R4 busy after qualifying stop", int'(busy_o), 1);
        busy_len(n);
        chk("R4 cycle length", n, PC);
        chk("R2 first byte", int'(dut_mem[138]), 8'h11);
        chk("R5 second byte", int'(dut_mem[139]), 8'h22);
        chk("R5 third byte", int'(dut_mem[140]), 8'h33);
        chk("R5 unloaded above", int'(dut_mem[141]), 8'hEE);
        chk("R5 unloaded below", int'(dut_mem[137]), 8'hEE);

        // R3: wrap inside page 5 starting at offset 62
        send_byte(5 * 64 + 62, 8'hA0);
        send_byte(0, 8'hA1);
        send_byte(0, 8'hA2);
        send_byte(0, 8'hA3);
        send_stop(1, 0);
        busy_len(n);
        chk("R3 offset 62", int'(dut_mem[382]), 8'hA0);
        chk("R3 offset 63", int'(dut_mem[383]), 8'hA1);
        chk("R3 wrap to offset 0", int'(dut_mem[320]), 8'hA2);
        chk("R3 offset 1", int'(dut_mem[321]), 8'hA3);
        chk("R3 next page untouched", int'(dut_mem[384]), 8'hEE);

        // R11: 65 bytes into page 1
        for (int i = 0; i < 65; i++) send_byte(64, i + 1);
        send_stop(1, 0);
        busy_len(n);
        chk("R11 overwritten offset 0", int'(dut_mem[64]), 65);
        chk("R11 offset 63", int'(dut_mem[127]), 64);

        // R6: STOP outside the window
        send_byte(192, 8'h5A);
        send_stop(0, 0);
        chk("R6 no cycle outside window", int'(busy_o), 0);
        send_stop(1, 0);
        chk("R6 discarded data starts nothing", int'(busy_o), 0);
        repeat (3) @(negedge clk);
        chk("R6 array untouched", int'(dut_mem[192]), 8'hEE);

        // R7: write protect
        send_byte(256, 8'h6B);
        send_stop(1, 1);
        chk("R7 protected stop keeps ready", int'(busy_o), 0);
        send_stop(1, 0);
        chk("R7 protected data discarded", int'(busy_o), 0);
        chk("R7 array untouched", int'(dut_mem[256]), 8'hEE);

        // R8: address-only write
        send_stop(1, 0);
        chk("R8 empty transaction", int'(busy_o), 0);

        // R9 R10: inputs ignored while busy, valid cleared after
        send_byte(448, 8'h77);
        send_stop(1, 0);
        load_i = 1'b1; load_addr_i = ADDR_W'(449); load_data_i = 8'h99;
        @(negedge clk);
        load_i = 1'b0;
        send_stop(1, 0);
        busy_len(n);
        chk("R9 cycle length unchanged", n + 2, PC);
        chk("R9 committed byte", int'(dut_mem[448]), 8'h77);
        chk("R9 ignored load", int'(dut_mem[449]), 8'hEE);
        send_stop(1, 0);
        chk("R10 no cycle after completion", int'(busy_o), 0);
        repeat (4) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule